// File: doc/BRIEF.md
# Two-Level Lookahead 32-Bit Adder

This block adds two 32-bit unsigned operands and an incoming carry bit, producing a 32-bit sum and an outgoing carry. Instead of passing a carry from bit to bit, it forms a generate term (both operand bits set) and a propagate term (either operand bit set) for every bit position in parallel. Carries inside each 4-bit group are then taken straight from those terms as flattened AND-OR expressions.

Each group also reports a group generate and a group propagate. A second lookahead unit across the eight groups turns those into the carry entering every group. The same unit's totals give the final carry-out. The outputs are purely combinational: there is no register, no clock and no reset inside the block.

Because propagate is the inclusive OR of the operand bits, it steers carries but cannot form the sum. Each sum bit is therefore the exclusive OR of the two operand bits and the carry into that position.

Top module: `cla_adder32`

## Requirements
- R1: `sum_o` equals the low 32 bits of `a_in + b_in + c_in`, taken as unsigned numbers, for every operand pair.
- R2: `c_out` equals bit 32 of the 33-bit result of `a_in + b_in + c_in`.
- R3: With `a_in` all ones, `b_in` zero and `c_in` = 1, the carry crosses all eight groups, so `sum_o` = 0 and `c_out` = 1.
- R4: The carry entering group k (bits 4k+3..4k) is the outgoing carry of the bits below it. For k = 0 it is `c_in`. For k > 0 it is group k-1's generate OR'd with (group k-1's propagate AND group k-1's carry-in).
- R5: When both operand bits are set, the generate term dominates. With both operands all ones and `c_in` = 0, the result is `sum_o` = 0xFFFFFFFE and `c_out` = 1.
- R6: With both operands zero, `sum_o` equals `c_in` in bit 0 and zero elsewhere, and `c_out` = 0.
- R7: Complementary alternating operands (0xAAAAAAAA with 0x55555555) give `sum_o` = 0xFFFFFFFF and `c_out` = 0 when `c_in` = 0. They give `sum_o` = 0 and `c_out` = 1 when `c_in` = 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_in | input | 32 | First operand |
| b_in | input | 32 | Second operand |
| c_in | input | 1 | Incoming carry into bit 0 |
| sum_o | output | 32 | Sum bits |
| c_out | output | 1 | Carry out of bit 31 |

## Verification
The checker tests, whenever any input changes, the full 33-bit result against an arithmetic sum. It also tests that every group carry-in produced by the second-level lookahead matches the serial recurrence over the neighbouring group's generate and propagate. Only the bench's chosen operands show the named corner cases actually being driven: a carry crossing all groups, generate dominance with both operands all ones, zero operands, and alternating patterns. A long random run supplies the breadth of group-boundary carry combinations.

// File: rtl/cla_pkg.sv
package cla_pkg;
    localparam int CLA_WIDTH   = 32;
    localparam int CLA_GROUP_W = 4;
endpackage

// File: rtl/cla_bit_gp.sv
// Per-bit generate / propagate cell.
module cla_bit_gp (
    input  logic a_bit,
    input  logic b_bit,
    output logic gen_o,
    output logic prop_o
);
    assign gen_o  = a_bit & b_bit;
    assign prop_o = a_bit | b_bit;
endmodule

// File: rtl/cla_lookahead.sv
// Generic lookahead unit: every carry written as a flattened
// sum of generate terms gated by runs of propagate terms.
module cla_lookahead #(
    parameter int N = 4
) (
    input  logic [N-1:0] gen_i,
    input  logic [N-1:0] prop_i,
    input  logic         cin,
    output logic [N-1:0] carry_o,   // carry into position j (carry_o[0] = cin)
    output logic         grp_gen_o,
    output logic         grp_prop_o
);
    always_comb begin
        logic acc;
        logic term;
        carry_o = '0;
        for (int j = 0; j < N; j++) begin
            acc = 1'b0;
            for (int k = 0; k < j; k++) begin
                term = gen_i[k];
                for (int m = k + 1; m < j; m++) term = term & prop_i[m];
                acc = acc | term;
            end
            term = cin;
            for (int m = 0; m < j; m++) term = term & prop_i[m];
            carry_o[j] = acc | term;
        end
    end

    always_comb begin
        logic acc;
        logic term;
        acc = 1'b0;
        for (int k = 0; k < N; k++) begin
            term = gen_i[k];
            for (int m = k + 1; m < N; m++) term = term & prop_i[m];
            acc = acc | term;
        end
        grp_gen_o  = acc;
        grp_prop_o = &prop_i;
    end
endmodule

// File: rtl/cla_group.sv
// One lookahead group: bit cells, in-group carries, sum bits.
module cla_group #(
    parameter int GROUP_W = 4
) (
    input  logic [GROUP_W-1:0] a_i,
    input  logic [GROUP_W-1:0] b_i,
    input  logic               cin,
    output logic [GROUP_W-1:0] sum_o,
    output logic               grp_gen_o,
    output logic               grp_prop_o
);
    logic [GROUP_W-1:0] bit_g;
    logic [GROUP_W-1:0] bit_p;
    logic [GROUP_W-1:0] bit_c;

    for (genvar i = 0; i < GROUP_W; i++) begin : g_bit
        cla_bit_gp u_gp (
            .a_bit (a_i[i]),
            .b_bit (b_i[i]),
            .gen_o (bit_g[i]),
            .prop_o(bit_p[i])
        );
    end

    cla_lookahead #(.N(GROUP_W)) u_la (
        .gen_i     (bit_g),
        .prop_i    (bit_p),
        .cin       (cin),
        .carry_o   (bit_c),
        .grp_gen_o (grp_gen_o),
        .grp_prop_o(grp_prop_o)
    );

    // OR-based propagate cannot form the sum; use XOR of operands and carry.
    assign sum_o = a_i ^ b_i ^ bit_c;
endmodule

// File: rtl/cla_adder32.sv
module cla_adder32
    import cla_pkg::*;
#(
    parameter int WIDTH   = CLA_WIDTH,
    parameter int GROUP_W = CLA_GROUP_W
) (
    input  logic [WIDTH-1:0] a_in,
    input  logic [WIDTH-1:0] b_in,
    input  logic             c_in,
    output logic [WIDTH-1:0] sum_o,
    output logic             c_out
);
    localparam int NGROUPS = WIDTH / GROUP_W;

    logic [NGROUPS-1:0] grp_gen;
    logic [NGROUPS-1:0] grp_prop;
    logic [NGROUPS-1:0] grp_cin;
    logic               top_gen;
    logic               top_prop;

    for (genvar g = 0; g < NGROUPS; g++) begin : g_grp
        cla_group #(.GROUP_W(GROUP_W)) u_grp (
            .a_i       (a_in[g*GROUP_W +: GROUP_W]),
            .b_i       (b_in[g*GROUP_W +: GROUP_W]),
            .cin       (grp_cin[g]),
            .sum_o     (sum_o[g*GROUP_W +: GROUP_W]),
            .grp_gen_o (grp_gen[g]),
            .grp_prop_o(grp_prop[g])
        );
    end

    // Second level: same lookahead scheme over the group terms.
    cla_lookahead #(.N(NGROUPS)) u_top_la (
        .gen_i     (grp_gen),
        .prop_i    (grp_prop),
        .cin       (c_in),
        .carry_o   (grp_cin),
        .grp_gen_o (top_gen),
        .grp_prop_o(top_prop)
    );

    assign c_out = top_gen | (top_prop & c_in);
endmodule

// File: rtl/cla_adder32_chk.sv
module cla_adder32_chk #(
    parameter int WIDTH   = 32,
    parameter int GROUP_W = 4
) (
    input logic [WIDTH-1:0]           a_in,
    input logic [WIDTH-1:0]           b_in,
    input logic                       c_in,
    input logic [WIDTH-1:0]           sum_o,
    input logic                       c_out,
    input logic [WIDTH/GROUP_W-1:0]   grp_gen,
    input logic [WIDTH/GROUP_W-1:0]   grp_prop,
    input logic [WIDTH/GROUP_W-1:0]   grp_cin
);
    localparam int NGROUPS = WIDTH / GROUP_W;

    logic [WIDTH:0] ref_sum;
    assign ref_sum = {1'b0, a_in} + {1'b0, b_in} + {{WIDTH{1'b0}}, c_in};

    always_comb begin
        p_sum_match_r1: assert (sum_o == ref_sum[WIDTH-1:0])
            else $error("sum mismatch");
        p_carry_out_r2: assert (c_out == ref_sum[WIDTH])
            else $error("carry-out mismatch");
        p_first_cin_r4: assert (grp_cin[0] == c_in)
            else $error("group 0 carry-in");
        for (int g = 1; g < NGROUPS; g++) begin
            p_group_chain_r4: assert (grp_cin[g] ==
                (grp_gen[g-1] | (grp_prop[g-1] & grp_cin[g-1])))
                else $error("group carry chain");
        end
        if (a_in == '0 && b_in == '0) begin
            p_zero_ops_r6: assert (c_out == 1'b0 && sum_o == {{(WIDTH-1){1'b0}}, c_in})
                else $error("zero operand result");
        end
        if (&a_in && b_in == '0 && c_in) begin
            p_full_ripple_r3: assert (sum_o == '0 && c_out)
                else $error("full carry crossing");
        end
    end
endmodule

bind cla_adder32 cla_adder32_chk #(.WIDTH(WIDTH), .GROUP_W(GROUP_W)) u_chk (
    .a_in    (a_in),
    .b_in    (b_in),
    .c_in    (c_in),
    .sum_o   (sum_o),
    .c_out   (c_out),
    .grp_gen (grp_gen),
    .grp_prop(grp_prop),
    .grp_cin (grp_cin)
);

// File: tb/sim_cla_adder32.sv
module sim_cla_adder32;
    localparam int CLK_PERIOD = 10;
    localparam int W = 32;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic [W-1:0] a_in = '0;
    logic [W-1:0] b_in = '0;
    logic         c_in = 1'b0;
    logic [W-1:0] sum_o;
    logic         c_out;

    int n_checks = 0;
    int n_fails  = 0;
    bit done     = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    cla_adder32 u0 (
        .a_in (a_in),
        .b_in (b_in),
        .c_in (c_in),
        .sum_o(sum_o),
        .c_out(c_out)
    );

    // Check: sum and carry, plus an optional explicit expected value.
    task automatic check_eq(input string tag, input logic [W:0] got, input logic [W:0] exp);
        n_checks++;
        if (got !== exp) begin
            n_fails++;
            $display("FAIL %s: got %h expected %h (a=%h b=%h cin=%0b)",
                     tag, got, exp, a_in, b_in, c_in);
        end
    endtask

    // Drive on the falling edge, compare a quarter period after the rising edge.
    task automatic apply(input logic [W-1:0] a, input logic [W-1:0] b, input logic ci,
                         input string tag);
        longint unsigned ref_v;
        @(negedge clk);
        a_in = a; b_in = b; c_in = ci;
        @(posedge clk);
        #(CLK_PERIOD/4);
        ref_v = longint'(a) + longint'(b) + longint'(ci);
        check_eq({tag, "/R1"}, {1'b0, sum_o}, {1'b0, ref_v[W-1:0]});
        check_eq({tag, "/R2"}, {W'(0), c_out}, {W'(0), ref_v[W]});
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #(CLK_PERIOD/4);
        check_eq("reset R6", {c_out, sum_o}, '0);
        rst = 1'b0;

        // R6: zero operands
        apply('0, '0, 1'b0, "R6 zero");
        check_eq("R6 zero cin0", {c_out, sum_o}, 33'h0_0000_0000);
        apply('0, '0, 1'b1, "R6 zero cin1");
        check_eq("R6 zero cin1", {c_out, sum_o}, 33'h0_0000_0001);

        // R3: carry crosses every group
        apply('1, '0, 1'b1, "R3 ripple");
        check_eq("R3 ripple", {c_out, sum_o}, 33'h1_0000_0000);
        apply('0, '1, 1'b1, "R3 ripple b");
        check_eq("R3 ripple b", {c_out, sum_o}, 33'h1_0000_0000);

        // R5: generate dominates where both bits set
        apply('1, '1, 1'b0, "R5 both ones");
        check_eq("R5 both ones", {c_out, sum_o}, 33'h1_FFFF_FFFE);
        apply('1, '1, 1'b1, "R5 both ones cin");
        check_eq("R5 both ones cin", {c_out, sum_o}, 33'h1_FFFF_FFFF);

        // R7: alternating patterns
        apply(32'hAAAA_AAAA, 32'h5555_5555, 1'b0, "R7 alt");
        check_eq("R7 alt cin0", {c_out, sum_o}, 33'h0_FFFF_FFFF);
        apply(32'hAAAA_AAAA, 32'h5555_5555, 1'b1, "R7 alt cin");
        check_eq("R7 alt cin1", {c_out, sum_o}, 33'h1_0000_0000);
        apply(32'hAAAA_AAAA, 32'hAAAA_AAAA, 1'b0, "R7 alt same");

        // R4: a carry generated at the top of each group crosses exactly one boundary
        for (int g = 0; g < 8; g++) begin
            apply(32'h8 << (4*g), 32'h8 << (4*g), 1'b0, "R4 boundary gen");
            apply((32'hF << (4*g)), 32'h1 << (4*g), 1'b0, "R4 boundary prop");
        end

        // R1/R2: random operands
        for (int i = 0; i < 3000; i++) begin
            apply($urandom, $urandom, 1'($urandom), "R1 random");
        end

        done = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog R1: got timeout expected completion");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
            $finish;
        end
    end
endmodule